// File: doc/BRIEF.md
# Outer-Loop Pipeline Stage Sequencer

This block drives the control side of a modulo-scheduled datapath in which a two-level loop nest is pipelined at its outer level. One outer iteration runs as a chain of stages of `T` cycles each. The chain is `S` stages long and repeats once per inner iteration. With the optional imperfect set enabled, the chain gains one extra pass of `S` stages. That pass runs either before the inner work (a prologue) or after it (an epilogue), and the `IMP_AT_END` parameter selects which. An outer iteration is launched every `II` cycles. Launches are grouped in runs of `S`, and each group is followed by a stall, so that no more than `S` iterations share the pipeline.

The host sets the stage length, stage count, initiation interval, outer and inner trip counts and the imperfect-set enable, then pulses `start`. The block checks the configuration and latches it. It then spends two set-up cycles and replays the schedule. Every cycle it reports, for each stage index, whether the stage runs, which outer iteration owns it, whether that run is an imperfect stage, and which inner iteration it serves. It also reports the cycle position within the current stage. A one-cycle `done` closes the run.

Top module: `opipe_seq`

## Requirements
- R1: A `start` seen while idle with a valid configuration raises `busy` on the next cycle. `stage_en` stays all-zero for exactly two cycles with `busy` high before the first stage enable.
- R2: A configuration is rejected when any of these holds: stage length is 0, stage count is 0 or above `MAX_S`, either trip count is 0, `II` is 0, `II` is not a whole multiple of the stage length, or `II`/stage length shares a factor above 1 with the stage count. On rejection, `cfg_err` is high from the next cycle, `busy` stays low and no stage runs. `cfg_err` clears at the next accepted `start`.
- R3: Every stage run lasts exactly `T` consecutive cycles. `stage_cyc` counts 0 to `T`-1 within it and is 0 outside a run.
- R4: Outer iteration n (tag n on `stage_tag`) starts stage 0 at run cycle (n div S)·G + (n mod S)·II. Run cycle 0 is the first enabled cycle.
- R5: The group period G equals max(T·Stot, S·II).
- R6: No stage index is driven by two outer iterations in one cycle, and no more than S iterations are in flight at once.
- R7: Each outer iteration runs Stot = S·(Ni + E) stages, where E is 1 with the imperfect set enabled and 0 otherwise. Its stages run in index order 0..S-1, repeated. `stage_inner` gives the inner iteration index during perfect passes.
- R8: With the imperfect set enabled, `stage_imp` marks the first S stages of each iteration when `IMP_AT_END`=0, or the last S when `IMP_AT_END`=1. Imperfect stage k always appears on stage index k, and `stage_imp` is never set on a stage that is not enabled.
- R9: The last group holds ((Np-1) mod S)+1 iterations.
- R10: `done` is high for one cycle, on the cycle after the last stage enable, and `busy` is low in that cycle. The count of `busy` cycles equals (ceil(Np/S)-1)·G + T·Stot + ((Np-1) mod S)·II + 2.
- R11: A `start` or a change of configuration inputs while `busy` has no effect on the running schedule or on `cfg_err`.
- R12: After reset, `busy`, `done`, `cfg_err` and `stage_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, honoured only while idle |
| cfg_t | input | T_W | Stage length in cycles |
| cfg_s | input | S_W | Number of perfect stages |
| cfg_ii | input | II_W | Initiation interval in cycles |
| cfg_np | input | NP_W | Outer trip count |
| cfg_ni | input | NI_W | Inner trip count |
| cfg_imp | input | 1 | Enable one set of imperfect stages |
| busy | output | 1 | Run in progress, including the two set-up cycles |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start request was rejected |
| stage_en | output | MAX_S | Stage index k is running this cycle |
| stage_cyc | output | T_W | Cycle position within the current stage |
| stage_tag | output | MAX_S*NP_W | Outer iteration owning each stage index |
| stage_imp | output | MAX_S | Stage index k is running as an imperfect stage |
| stage_inner | output | MAX_S*NI_W | Inner iteration index on each stage index |

## Verification
The hardest case to reach is slot reuse: a new group launching into a slot on the same edge that the slot's previous iteration retires. A second hard case is a group period set by S·II rather than by the drain time, which leaves idle cycles inside a run. The vector table holds configurations where T·Stot exceeds S·II, equals it, and falls below it. Those configurations use trip counts that are not multiples of S, so that both the hand-over edge and a partial last group occur. A cycle-by-cycle reference schedule covers both the prologue and the epilogue builds.

// File: rtl/opipe_pkg.sv
package opipe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT0 = 2'd1,
        ST_INIT1 = 2'd2,
        ST_RUN   = 2'd3
    } opipe_state_e;

endpackage

// File: rtl/opipe_cfg_check.sv
module opipe_cfg_check #(
    parameter int MAX_S = 8,
    parameter int T_W   = 8,
    parameter int S_W   = 4,
    parameter int II_W  = 12,
    parameter int NP_W  = 10,
    parameter int NI_W  = 10,
    parameter int CNT_W = 32
) (
    input  logic [T_W-1:0]   t,
    input  logic [S_W-1:0]   s,
    input  logic [II_W-1:0]  ii,
    input  logic [NP_W-1:0]  np,
    input  logic [NI_W-1:0]  ni,
    input  logic             imp,
    output logic             bad,
    output logic [NI_W:0]    rounds,
    output logic [CNT_W-1:0] gap
);
    logic [CNT_W-1:0] tstot;
    logic [CNT_W-1:0] sii;
    logic [CNT_W-1:0] gp;
    logic [CNT_W-1:0] q;
    logic [CNT_W-1:0] rem;
    logic             share;

    always_comb begin
        rounds = {1'b0, ni} + (NI_W+1)'(imp);
        tstot  = CNT_W'(t) * CNT_W'(s) * CNT_W'(rounds);
        sii    = CNT_W'(s) * CNT_W'(ii);
        gp     = (tstot > sii) ? tstot : sii;
        // Stall after the last launch of a group so groups start gp apart.
        gap    = gp - (CNT_W'(s) - CNT_W'(1)) * CNT_W'(ii);
        if (t != '0) begin
            q   = CNT_W'(ii) / CNT_W'(t);
            rem = CNT_W'(ii) % CNT_W'(t);
        end else begin
            q   = '0;
            rem = '1;
        end
        share = 1'b0;
        for (int d = 2; d <= MAX_S; d++) begin
            if (((32'(s) % d) == 0) && ((q % CNT_W'(d)) == '0)) begin
                share = 1'b1;
            end
        end
        bad = (t == '0) || (s == '0) || (32'(s) > MAX_S) || (np == '0) ||
              (ni == '0) || (ii == '0) || (rem != '0) || share;
    end
endmodule

// File: rtl/opipe_slot.sv
module opipe_slot #(
    parameter int S_W        = 4,
    parameter int NI_W       = 10,
    parameter int TAG_W      = 10,
    parameter bit IMP_AT_END = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [TAG_W-1:0] launch_tag,
    input  logic             tick,
    input  logic [S_W-1:0]   last_stage,
    input  logic [NI_W:0]    last_round,
    input  logic             imp_on,
    output logic             active,
    output logic [S_W-1:0]   stage,
    output logic [TAG_W-1:0] tag,
    output logic             imp,
    output logic [NI_W-1:0]  inner,
    output logic             retiring
);
    typedef struct packed {
        logic             active;
        logic [S_W-1:0]   stage;
        logic [NI_W:0]    round;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d   = slot_q;
        retiring = slot_q.active && tick && (slot_q.stage == last_stage) &&
                   (slot_q.round == last_round);
        if (slot_q.active && tick) begin
            if (slot_q.stage == last_stage) begin
                slot_d.stage = '0;
                if (slot_q.round == last_round) begin
                    slot_d.active = 1'b0;
                end else begin
                    slot_d.round = slot_q.round + 1'b1;
                end
            end else begin
                slot_d.stage = slot_q.stage + 1'b1;
            end
        end
        // A launch into a slot that retires on the same edge takes priority.
        if (launch) begin
            slot_d.active = 1'b1;
            slot_d.stage  = '0;
            slot_d.round  = '0;
            slot_d.tag    = launch_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign active = slot_q.active;
    assign stage  = slot_q.stage;
    assign tag    = slot_q.tag;

    generate
        if (IMP_AT_END) begin : g_epilogue
            always_comb begin
                imp   = imp_on && (slot_q.round == last_round);
                inner = imp ? '0 : NI_W'(slot_q.round);
            end
        end else begin : g_prologue
            always_comb begin
                imp = imp_on && (slot_q.round == '0);
                if (imp)         inner = '0;
                else if (imp_on) inner = NI_W'(slot_q.round - 1'b1);
                else             inner = NI_W'(slot_q.round);
            end
        end
    endgenerate
endmodule

// File: rtl/opipe_stage_map.sv
module opipe_stage_map #(
    parameter int MAX_S = 8,
    parameter int S_W   = 4,
    parameter int TAG_W = 10,
    parameter int NI_W  = 10
) (
    input  logic [MAX_S-1:0]       slot_active,
    input  logic [S_W-1:0]         slot_stage [MAX_S],
    input  logic [TAG_W-1:0]       slot_tag   [MAX_S],
    input  logic [MAX_S-1:0]       slot_imp,
    input  logic [NI_W-1:0]        slot_inner [MAX_S],
    output logic [MAX_S-1:0]       stage_en,
    output logic [MAX_S*TAG_W-1:0] stage_tag,
    output logic [MAX_S-1:0]       stage_imp,
    output logic [MAX_S*NI_W-1:0]  stage_inner
);
    // Slot/stage pairs never collide on a valid schedule, so an OR-merge suffices.
    always_comb begin
        stage_en    = '0;
        stage_tag   = '0;
        stage_imp   = '0;
        stage_inner = '0;
        for (int k = 0; k < MAX_S; k++) begin
            for (int j = 0; j < MAX_S; j++) begin
                if (slot_active[j] && (slot_stage[j] == S_W'(k))) begin
                    stage_en[k]                   = 1'b1;
                    stage_tag[k*TAG_W +: TAG_W]  |= slot_tag[j];
                    stage_imp[k]                 |= slot_imp[j];
                    stage_inner[k*NI_W +: NI_W]  |= slot_inner[j];
                end
            end
        end
    end
endmodule

// File: rtl/opipe_seq.sv
module opipe_seq
    import opipe_pkg::*;
#(
    parameter int MAX_S      = 8,
    parameter int T_W        = 8,
    parameter int II_W       = 12,
    parameter int NP_W       = 10,
    parameter int NI_W       = 10,
    parameter bit IMP_AT_END = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [T_W-1:0]            cfg_t,
    input  logic [$clog2(MAX_S+1)-1:0] cfg_s,
    input  logic [II_W-1:0]           cfg_ii,
    input  logic [NP_W-1:0]           cfg_np,
    input  logic [NI_W-1:0]           cfg_ni,
    input  logic                      cfg_imp,
    output logic                      busy,
    output logic                      done,
    output logic                      cfg_err,
    output logic [MAX_S-1:0]          stage_en,
    output logic [T_W-1:0]            stage_cyc,
    output logic [MAX_S*NP_W-1:0]     stage_tag,
    output logic [MAX_S-1:0]          stage_imp,
    output logic [MAX_S*NI_W-1:0]     stage_inner
);
    localparam int S_W   = $clog2(MAX_S+1);
    localparam int LEN_A = T_W + S_W + NI_W + 1;
    localparam int LEN_B = S_W + II_W;
    localparam int CNT_W = ((LEN_A > LEN_B) ? LEN_A : LEN_B) + 1;

    typedef struct packed {
        opipe_state_e     st;
        logic             busy;
        logic             done;
        logic             err;
        logic [T_W-1:0]   t;
        logic [S_W-1:0]   s;
        logic [II_W-1:0]  ii;
        logic [NP_W-1:0]  np;
        logic [NI_W:0]    rounds;
        logic             imp;
        logic [CNT_W-1:0] gap;
        logic [T_W-1:0]   cyc;
        logic [CNT_W-1:0] ltimer;
        logic [NP_W-1:0]  nlaunch;
        logic [S_W-1:0]   gpos;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             cfg_bad;
    logic [NI_W:0]    cfg_rounds;
    logic [CNT_W-1:0] cfg_gap;
    logic             tick;
    logic             launch_any;
    logic             run_end;
    logic [S_W-1:0]   cur_s;
    logic [S_W-1:0]   last_stage;
    logic [NI_W:0]    last_round;

    logic [MAX_S-1:0]     slot_active;
    logic [MAX_S-1:0]     slot_retiring;
    logic [MAX_S-1:0]     slot_imp;
    logic [MAX_S-1:0]     slot_launch;
    logic [S_W-1:0]       slot_stage [MAX_S];
    logic [NP_W-1:0]      slot_tag   [MAX_S];
    logic [NI_W-1:0]      slot_inner [MAX_S];
    logic [MAX_S*S_W-1:0] slot_stage_flat;

    opipe_cfg_check #(
        .MAX_S(MAX_S), .T_W(T_W), .S_W(S_W), .II_W(II_W),
        .NP_W(NP_W), .NI_W(NI_W), .CNT_W(CNT_W)
    ) u_cfg (
        .t(cfg_t), .s(cfg_s), .ii(cfg_ii), .np(cfg_np), .ni(cfg_ni),
        .imp(cfg_imp), .bad(cfg_bad), .rounds(cfg_rounds), .gap(cfg_gap)
    );

    always_comb begin
        cur_s      = ctl_q.s;
        last_stage = ctl_q.s - 1'b1;
        last_round = ctl_q.rounds - 1'b1;
        tick       = (ctl_q.st == ST_RUN) && (ctl_q.cyc == ctl_q.t - 1'b1);
        launch_any = (ctl_q.st == ST_INIT1) ||
                     ((ctl_q.st == ST_RUN) && (ctl_q.ltimer == '0) &&
                      (ctl_q.nlaunch != ctl_q.np));
        run_end    = (ctl_q.st == ST_RUN) && (ctl_q.nlaunch == ctl_q.np) &&
                     ((slot_active & ~slot_retiring) == '0) && !launch_any;
        for (int j = 0; j < MAX_S; j++) begin
            slot_launch[j]               = launch_any && (ctl_q.gpos == S_W'(j));
            slot_stage_flat[j*S_W +: S_W] = slot_stage[j];
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.err = cfg_bad;
                    if (!cfg_bad) begin
                        ctl_d.st      = ST_INIT0;
                        ctl_d.busy    = 1'b1;
                        ctl_d.t       = cfg_t;
                        ctl_d.s       = cfg_s;
                        ctl_d.ii      = cfg_ii;
                        ctl_d.np      = cfg_np;
                        ctl_d.rounds  = cfg_rounds;
                        ctl_d.imp     = cfg_imp;
                        ctl_d.gap     = cfg_gap;
                        ctl_d.cyc     = '0;
                        ctl_d.ltimer  = '0;
                        ctl_d.nlaunch = '0;
                        ctl_d.gpos    = '0;
                    end
                end
            end
            ST_INIT0: ctl_d.st = ST_INIT1;
            ST_INIT1: begin
                ctl_d.st  = ST_RUN;
                ctl_d.cyc = '0;
            end
            ST_RUN: begin
                ctl_d.cyc = tick ? '0 : ctl_q.cyc + 1'b1;
                if (ctl_q.ltimer != '0) ctl_d.ltimer = ctl_q.ltimer - 1'b1;
                if (run_end) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.cyc  = '0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (launch_any) begin
            ctl_d.nlaunch = ctl_q.nlaunch + 1'b1;
            if (ctl_q.gpos == last_stage) begin
                ctl_d.gpos   = '0;
                ctl_d.ltimer = ctl_q.gap - 1'b1;
            end else begin
                ctl_d.gpos   = ctl_q.gpos + 1'b1;
                ctl_d.ltimer = CNT_W'(ctl_q.ii) - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    generate
        for (genvar j = 0; j < MAX_S; j++) begin : g_slot
            opipe_slot #(
                .S_W(S_W), .NI_W(NI_W), .TAG_W(NP_W), .IMP_AT_END(IMP_AT_END)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .launch     (slot_launch[j]),
                .launch_tag (ctl_q.nlaunch),
                .tick       (tick),
                .last_stage (last_stage),
                .last_round (last_round),
                .imp_on     (ctl_q.imp),
                .active     (slot_active[j]),
                .stage      (slot_stage[j]),
                .tag        (slot_tag[j]),
                .imp        (slot_imp[j]),
                .inner      (slot_inner[j]),
                .retiring   (slot_retiring[j])
            );
        end
    endgenerate

    opipe_stage_map #(
        .MAX_S(MAX_S), .S_W(S_W), .TAG_W(NP_W), .NI_W(NI_W)
    ) u_map (
        .slot_active (slot_active),
        .slot_stage  (slot_stage),
        .slot_tag    (slot_tag),
        .slot_imp    (slot_imp),
        .slot_inner  (slot_inner),
        .stage_en    (stage_en),
        .stage_tag   (stage_tag),
        .stage_imp   (stage_imp),
        .stage_inner (stage_inner)
    );

    assign busy      = ctl_q.busy;
    assign done      = ctl_q.done;
    assign cfg_err   = ctl_q.err;
    assign stage_cyc = (ctl_q.st == ST_RUN) ? ctl_q.cyc : '0;
endmodule

// File: rtl/opipe_seq_chk.sv
module opipe_seq_chk #(
    parameter int MAX_S = 8,
    parameter int S_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 cfg_err,
    input logic                 cfg_bad,
    input logic [MAX_S-1:0]     stage_en,
    input logic [MAX_S-1:0]     stage_imp,
    input logic [MAX_S-1:0]     slot_active,
    input logic [MAX_S*S_W-1:0] slot_stage_flat,
    input logic [S_W-1:0]       cur_s
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && !cfg_bad) |=> (busy && !cfg_err));

    assert_setup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (stage_en == '0));

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && cfg_bad) |=> (!busy && cfg_err));

    assert_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(slot_active) <= 32'(cur_s)));

    assert_imp_inside_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_imp & ~stage_en) == '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_falls_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stage_en == '0));

    generate
        for (genvar k = 0; k < MAX_S; k++) begin : g_stage
            logic [MAX_S-1:0] hit;
            always_comb begin
                for (int j = 0; j < MAX_S; j++) begin
                    hit[j] = slot_active[j] &&
                             (slot_stage_flat[j*S_W +: S_W] == S_W'(k));
                end
            end
            assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(hit));
        end
    endgenerate
endmodule

bind opipe_seq opipe_seq_chk #(.MAX_S(MAX_S), .S_W(S_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .busy            (busy),
    .done            (done),
    .cfg_err         (cfg_err),
    .cfg_bad         (cfg_bad),
    .stage_en        (stage_en),
    .stage_imp       (stage_imp),
    .slot_active     (slot_active),
    .slot_stage_flat (slot_stage_flat),
    .cur_s           (cur_s)
);

// File: tb/tb_opipe_seq.sv
module tb_opipe_seq;
    localparam int MAX_S = 8;
    localparam int T_W   = 8;
    localparam int S_W   = 4;
    localparam int II_W  = 12;
    localparam int NP_W  = 10;
    localparam int NI_W  = 10;

    typedef struct packed {
        logic [7:0]  t;
        logic [3:0]  s;
        logic [11:0] ii;
        logic [9:0]  np;
        logic [9:0]  ni;
        logic        imp;
        logic        bad;
        logic        mid;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 4'd1, 12'd1, 10'd3, 10'd2, 1'b0, 1'b0, 1'b0},
        '{8'd2, 4'd3, 12'd2, 10'd5, 10'd2, 1'b0, 1'b0, 1'b1},
        '{8'd2, 4'd4, 12'd4, 10'd2, 10'd2, 1'b0, 1'b1, 1'b0},
        '{8'd1, 4'd3, 12'd2, 10'd7, 10'd1, 1'b0, 1'b0, 1'b0},
        '{8'd2, 4'd2, 12'd3, 10'd2, 10'd1, 1'b0, 1'b1, 1'b0},
        '{8'd2, 4'd2, 12'd2, 10'd4, 10'd3, 1'b1, 1'b0, 1'b0},
        '{8'd0, 4'd2, 12'd2, 10'd2, 10'd1, 1'b0, 1'b1, 1'b0},
        '{8'd1, 4'd4, 12'd3, 10'd6, 10'd2, 1'b1, 1'b0, 1'b0},
        '{8'd1, 4'd9, 12'd1, 10'd2, 10'd1, 1'b0, 1'b1, 1'b0},
        '{8'd3, 4'd2, 12'd3, 10'd3, 10'd1, 1'b0, 1'b0, 1'b0},
        '{8'd1, 4'd0, 12'd1, 10'd2, 10'd1, 1'b0, 1'b1, 1'b0},
        '{8'd2, 4'd3, 12'd4, 10'd8, 10'd1, 1'b1, 1'b0, 1'b0},
        '{8'd1, 4'd2, 12'd1, 10'd0, 10'd1, 1'b0, 1'b1, 1'b0},
        '{8'd1, 4'd2, 12'd1, 10'd2, 10'd0, 1'b0, 1'b1, 1'b0},
        '{8'd1, 4'd2, 12'd1, 10'd1, 10'd1, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [T_W-1:0]  cfg_t = '0;
    logic [S_W-1:0]  cfg_s = '0;
    logic [II_W-1:0] cfg_ii = '0;
    logic [NP_W-1:0] cfg_np = '0;
    logic [NI_W-1:0] cfg_ni = '0;
    logic            cfg_imp = 1'b0;

    logic                  busy_o  [2];
    logic                  done_o  [2];
    logic                  err_o   [2];
    logic [MAX_S-1:0]      en_o    [2];
    logic [T_W-1:0]        cyc_o   [2];
    logic [MAX_S*NP_W-1:0] tag_o   [2];
    logic [MAX_S-1:0]      imp_o   [2];
    logic [MAX_S*NI_W-1:0] inner_o [2];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    opipe_seq #(.MAX_S(MAX_S), .T_W(T_W), .II_W(II_W), .NP_W(NP_W),
                .NI_W(NI_W), .IMP_AT_END(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_t(cfg_t), .cfg_s(cfg_s),
        .cfg_ii(cfg_ii), .cfg_np(cfg_np), .cfg_ni(cfg_ni), .cfg_imp(cfg_imp),
        .busy(busy_o[0]), .done(done_o[0]), .cfg_err(err_o[0]),
        .stage_en(en_o[0]), .stage_cyc(cyc_o[0]), .stage_tag(tag_o[0]),
        .stage_imp(imp_o[0]), .stage_inner(inner_o[0]));

    opipe_seq #(.MAX_S(MAX_S), .T_W(T_W), .II_W(II_W), .NP_W(NP_W),
                .NI_W(NI_W), .IMP_AT_END(1'b1)) dut_end (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_t(cfg_t), .cfg_s(cfg_s),
        .cfg_ii(cfg_ii), .cfg_np(cfg_np), .cfg_ni(cfg_ni), .cfg_imp(cfg_imp),
        .busy(busy_o[1]), .done(done_o[1]), .cfg_err(err_o[1]),
        .stage_en(en_o[1]), .stage_cyc(cyc_o[1]), .stage_tag(tag_o[1]),
        .stage_imp(imp_o[1]), .stage_inner(inner_o[1]));

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int group_period(input vec_t v);
        int a = int'(v.t) * int'(v.s) * (int'(v.ni) + int'(v.imp));
        int b = int'(v.s) * int'(v.ii);
        return (a > b) ? a : b;
    endfunction

    // Reference schedule: owner and attributes of stage index k at run cycle r.
    function automatic void ref_at(input vec_t v, input int r, input int k, input int atend,
                                   output bit en, output int tag, output bit im,
                                   output int inner);
        int len = int'(v.t) * int'(v.s) * (int'(v.ni) + int'(v.imp));
        int gp  = group_period(v);
        en = 0; tag = 0; im = 0; inner = 0;
        for (int n = 0; n < int'(v.np); n++) begin
            int ln = (n / int'(v.s)) * gp + (n % int'(v.s)) * int'(v.ii);
            if (r >= ln && r < ln + len) begin
                int off = (r - ln) / int'(v.t);
                if (off % int'(v.s) == k) begin
                    int rnd = off / int'(v.s);
                    en  = 1;
                    tag = n;
                    im  = v.imp && (atend != 0 ? (rnd == int'(v.ni)) : (rnd == 0));
                    if (im)                        inner = 0;
                    else if (v.imp && atend == 0)  inner = rnd - 1;
                    else                           inner = rnd;
                end
            end
        end
    endfunction

    task automatic run_vec(input int vi, input vec_t v);
        int k;
        int mism [2];
        int len;
        @(negedge clk);
        cfg_t = v.t; cfg_s = v.s; cfg_ii = v.ii; cfg_np = v.np;
        cfg_ni = v.ni; cfg_imp = v.imp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.bad) begin
            // R2: rejected configuration leaves the block idle with the error flag set
            check(!busy_o[0] && !busy_o[1] && err_o[0] && err_o[1],
                  $sformatf("R2 vec %0d reject busy/err", vi),
                  {busy_o[0], err_o[0]}, 1);
            @(negedge clk);
            check(en_o[0] == '0 && en_o[1] == '0 && !busy_o[0],
                  $sformatf("R2 vec %0d no stage after reject", vi), en_o[0], 0);
            return;
        end
        // R1 busy on next cycle; R2 error cleared by accepted start
        check(busy_o[0] && busy_o[1] && !err_o[0] && !err_o[1],
              $sformatf("R1 R2 vec %0d accept busy/err", vi), {busy_o[0], err_o[0]}, 2);
        mism[0] = 0; mism[1] = 0;
        k = 0;
        while (busy_o[0] && k < 20000) begin
            int r = k - 2;
            for (int d = 0; d < 2; d++) begin
                int ecyc = (r >= 0) ? (r % int'(v.t)) : 0;
                if (busy_o[d] != busy_o[0] || int'(cyc_o[d]) != ecyc) begin
                    if (mism[d] == 0)
                        $display("FAIL R3 vec %0d dut %0d cycle %0d: stage_cyc actual %0d expected %0d",
                                 vi, d, r, cyc_o[d], ecyc);
                    mism[d]++;
                end
                for (int s = 0; s < MAX_S; s++) begin
                    bit  een, eim;
                    int  etag, einn;
                    ref_at(v, r, s, d, een, etag, eim, einn);
                    if (en_o[d][s] != een ||
                        (een && (int'(tag_o[d][s*NP_W +: NP_W]) != etag ||
                                 imp_o[d][s] != eim ||
                                 int'(inner_o[d][s*NI_W +: NI_W]) != einn))) begin
                        if (mism[d] == 0)
                            $display("FAIL R1 R4 R5 R6 R7 R8 R9 vec %0d dut %0d cycle %0d stage %0d: en/tag/imp/inner actual %0b/%0d/%0b/%0d expected %0b/%0d/%0b/%0d",
                                     vi, d, r, s, en_o[d][s], tag_o[d][s*NP_W +: NP_W],
                                     imp_o[d][s], inner_o[d][s*NI_W +: NI_W],
                                     een, etag, eim, einn);
                        mism[d]++;
                    end
                end
            end
            // R11: start and new configuration inputs while running are ignored
            if (v.mid && k == 4) begin
                start = 1'b1; cfg_t = 8'd0; cfg_s = 4'd7; cfg_ii = 12'd5;
                cfg_np = 10'd1; cfg_ni = 10'd9; cfg_imp = ~v.imp;
            end
            if (v.mid && k == 5) start = 1'b0;
            k++;
            @(negedge clk);
        end
        for (int d = 0; d < 2; d++) begin
            checks++;
            if (mism[d] != 0) errors++;
        end
        len = ((int'(v.np) + int'(v.s) - 1) / int'(v.s) - 1) * group_period(v) +
              int'(v.t) * int'(v.s) * (int'(v.ni) + int'(v.imp)) +
              ((int'(v.np) - 1) % int'(v.s)) * int'(v.ii);
        check(k == len + 2, $sformatf("R10 vec %0d busy cycle count", vi), k, len + 2);
        check(done_o[0] && done_o[1] && !busy_o[1],
              $sformatf("R10 vec %0d done with busy low", vi), {done_o[0], done_o[1]}, 3);
        if (v.mid)
            check(!err_o[0] && !err_o[1], $sformatf("R11 vec %0d cfg_err untouched", vi),
                  err_o[0], 0);
        @(negedge clk);
        check(!done_o[0] && !done_o[1], $sformatf("R10 vec %0d done one cycle", vi),
              done_o[0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy_o[0] && !done_o[0] && !err_o[0] && en_o[0] == '0 &&
              !busy_o[1] && en_o[1] == '0, "R12 reset outputs",
              {busy_o[0], done_o[0], err_o[0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o[0] && en_o[0] == '0, "R12 idle after reset release", busy_o[0], 0);
        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);
        // R2 then R1: a rejected start followed directly by an accepted one
        run_vec(100, VECS[2]);
        run_vec(101, VECS[14]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule